// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the bus master for a three-wire serial EEPROM with a separate data return line. It drives the device's chip select, shift clock and command/data line, and it samples the line the device drives back. A host hands it one operation at a time through a start/done handshake. The operation can be a word read, a word write, an erase, a write-enable, a write-disable or a standalone busy poll. The host also supplies an address, a write word and a selector for a 6-bit or 8-bit address field. The engine returns the read word and an error flag together with a one-cycle done pulse.

A word write is not sent as a single frame. The engine wraps it in a fixed six-step guarded sequence: wait for ready, open programming, send the write frame, wait for the program cycle, close programming, and wait again. The host therefore issues one request and never sees the device left open for programming. Serial timing comes from an internal divider counted in system clocks. Every poll gives up after a parameterised number of samples.

Top module: `sereep_engine`

## Requirements
- R1: After reset, chip select, shift clock, serial data out, done and the error flag are all low, and the read word is zero.
- R2: The shift clock is low whenever chip select is low. The serial data out line changes only while the shift clock is low. Each high and low clock phase lasts HALF_DIV system clocks.
- R3: A read (opSel 0) sends one frame of 3 + W + 16 clocks, where W is 6 or 8. The frame carries 1,1,0, then the address MSB first, then sixteen zeros. The device line is sampled at the end of each high phase, and rdData becomes the last 16 bits sampled, MSB first.
- R4: A write (opSel 1) runs six chip-select periods in this order: poll, enable frame, write frame, poll, disable frame, poll. The write frame is 3 + W + 16 clocks long and carries 1,0,1, the address and then wrData, all MSB first.
- R5: The enable frame (opSel 3, and step two of a write) is 3 + W clocks carrying 0x4F shifted left by W − 4. The disable frame (opSel 4, and step five of a write) is the same length and carries 0x40 shifted left by W − 4.
- R6: An erase (opSel 2) sends one frame of 3 + W clocks carrying 1,1,1 and then the address.
- R7: addrWide 1 selects W = 8. addrWide 0 selects W = 6, and addr bits 7:6 are then not sent.
- R8: A poll (opSel 5, 6 or 7, and each poll step of a write) raises chip select with the clock held low. It samples the device line once every 2·HALF_DIV system clocks and ends at the first high sample.
- R9: If a poll sees POLL_LIMIT low samples, chip select drops, done pulses with err = 1, and any remaining steps of a write are skipped.
- R10: Between any two chip-select periods, chip select stays low for at least 2·HALF_DIV system clocks.
- R11: A start raised while an operation is in progress is ignored: no extra bus activity and no extra done pulse follow.
- R12: done is a single-cycle pulse. err and rdData are valid with done and hold until the next done. A successful operation clears err, and only a read changes rdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Request pulse, taken only when the engine is idle |
| opSel | input | 3 | Operation: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5–7 poll |
| addrWide | input | 1 | 1 selects an 8-bit address field, 0 a 6-bit one |
| addr | input | 8 | Word address |
| wrData | input | 16 | Word to program |
| misoIn | input | 1 | Data line driven by the device |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout on the last operation |
| rdData | output | 16 | Word returned by the last read |
| csOut | output | 1 | Device chip select, active high |
| sclkOut | output | 1 | Shift clock, idles low |
| mosiOut | output | 1 | Command and data line to the device |

## Verification
A table of single-frame requests exercises each operation code at both address widths. The addresses include the all-ones and all-zeros values and values whose upper two bits are set, so that truncation in the 6-bit mode is distinguishable from a shifted header. The read words are derived from the address, which separates a misaligned capture window from a correct one. Guarded writes at both widths check the segment order, the enable and disable patterns and that the post-write poll actually waits. A device forced busy separates a poll that times out from one that succeeds, both as a standalone poll and as the first step of a write.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

  localparam int DATA_W   = 16;
  localparam int ADDR_MIN = 6;
  localparam int ADDR_MAX = 8;
  localparam int FRAME_W  = 3 + ADDR_MAX + DATA_W;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int STEP_W   = 3;
  localparam int WRITE_LAST_STEP = 5;

  localparam logic [2:0] CMD_READ  = 3'b110;
  localparam logic [2:0] CMD_WRITE = 3'b101;
  localparam logic [2:0] CMD_ERASE = 3'b111;
  localparam logic [6:0] ENABLE_SEED  = 7'h4F;
  localparam logic [6:0] DISABLE_SEED = 7'h40;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WEN   = 3'd3,
    OP_WDS   = 3'd4,
    OP_POLL  = 3'd5
  } hostOp_e;

  typedef enum logic [2:0] {
    K_POLL, K_WEN, K_WRITE, K_WDS, K_READ, K_ERASE
  } stepKind_e;

  typedef struct packed {
    logic               launch;
    logic               isPoll;
    logic [LEN_W-1:0]   len;
    logic [FRAME_W-1:0] pattern;
  } ctlStrobe_t;

  typedef struct packed {
    logic              stepDone;
    logic              timedOut;
    logic [DATA_W-1:0] rxWord;
  } dpStatus_t;

endpackage

// File: rtl/sereep_dpath.sv
module sereep_dpath
  import sereep_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int POLL_LIMIT = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       misoIn,
  output dpStatus_t  status,
  output logic       csOut,
  output logic       sclkOut,
  output logic       mosiOut
);

  localparam int DIV_W  = $clog2(2 * HALF_DIV + 1);
  localparam int PCNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [DIV_W-1:0] HALF_END   = DIV_W'(HALF_DIV - 1);
  localparam logic [DIV_W-1:0] PERIOD_END = DIV_W'(2 * HALF_DIV - 1);
  localparam logic [DIV_W-1:0] GAP_MIN    = DIV_W'(2 * HALF_DIV);

  typedef enum logic [2:0] {D_IDLE, D_LOW, D_HIGH, D_POLL, D_GAP} dState_e;

  dState_e             state;
  logic [DIV_W-1:0]    divCnt;
  logic [FRAME_W-1:0]  shiftQ;
  logic [LEN_W-1:0]    bitsLeft;
  logic [DATA_W-1:0]   rxQ;
  logic [PCNT_W-1:0]   pollCnt;
  logic                timeoutQ;
  logic                stepDoneQ;
  logic                csQ;
  logic                sclkQ;
  logic                mosiQ;
  logic [FRAME_W-1:0]  alignedPat;
  logic                halfEnd;
  logic                periodEnd;

  assign alignedPat = strobe.pattern << (LEN_W'(FRAME_W) - strobe.len);
  assign halfEnd    = (divCnt == HALF_END);
  assign periodEnd  = (divCnt == PERIOD_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= D_IDLE;
      divCnt    <= '0;
      shiftQ    <= '0;
      bitsLeft  <= '0;
      rxQ       <= '0;
      pollCnt   <= '0;
      timeoutQ  <= 1'b0;
      stepDoneQ <= 1'b0;
      csQ       <= 1'b0;
      sclkQ     <= 1'b0;
      mosiQ     <= 1'b0;
    end else begin
      stepDoneQ <= 1'b0;
      unique case (state)
        D_IDLE: begin
          if (strobe.launch) begin
            divCnt   <= '0;
            csQ      <= 1'b1;
            timeoutQ <= 1'b0;
            if (strobe.isPoll) begin
              pollCnt <= '0;
              mosiQ   <= 1'b0;
              state   <= D_POLL;
            end else begin
              shiftQ   <= alignedPat;
              mosiQ    <= alignedPat[FRAME_W-1];
              bitsLeft <= strobe.len;
              rxQ      <= '0;
              state    <= D_LOW;
            end
          end
        end
        D_LOW: begin
          if (halfEnd) begin
            divCnt <= '0;
            sclkQ  <= 1'b1;
            state  <= D_HIGH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        D_HIGH: begin
          if (halfEnd) begin
            divCnt <= '0;
            sclkQ  <= 1'b0;
            rxQ    <= {rxQ[DATA_W-2:0], misoIn};
            if (bitsLeft == LEN_W'(1)) begin
              csQ   <= 1'b0;
              mosiQ <= 1'b0;
              state <= D_GAP;
            end else begin
              shiftQ   <= shiftQ << 1;
              mosiQ    <= shiftQ[FRAME_W-2];
              bitsLeft <= bitsLeft - 1'b1;
              state    <= D_LOW;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        D_POLL: begin
          if (periodEnd) begin
            divCnt <= '0;
            if (misoIn) begin
              csQ   <= 1'b0;
              state <= D_GAP;
            end else if (pollCnt == PCNT_W'(POLL_LIMIT - 1)) begin
              timeoutQ <= 1'b1;
              csQ      <= 1'b0;
              state    <= D_GAP;
            end else begin
              pollCnt <= pollCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        D_GAP: begin
          if (periodEnd) begin
            divCnt    <= '0;
            stepDoneQ <= 1'b1;
            state     <= D_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= D_IDLE;
      endcase
    end
  end

  assign status.stepDone = stepDoneQ;
  assign status.timedOut = timeoutQ;
  assign status.rxWord   = rxQ;
  assign csOut   = csQ;
  assign sclkOut = sclkQ;
  assign mosiOut = mosiQ;

  // Low-time counter for chip select, saturating; starts full so the first frame is legal.
  logic [DIV_W-1:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gapCnt <= GAP_MIN;
    else if (csQ)            gapCnt <= '0;
    else if (gapCnt < GAP_MIN) gapCnt <= gapCnt + 1'b1;
  end

  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csQ) |-> (gapCnt >= GAP_MIN));

  assert_clk_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !csQ |-> !sclkQ);

  assert_data_setup_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mosiQ) |-> !sclkQ);

  assert_poll_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == D_POLL) |-> (csQ && !sclkQ));

  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PCNT_W'(POLL_LIMIT));

endmodule

// File: rtl/sereep_ctrl.sv
module sereep_ctrl
  import sereep_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          opSel,
  input  logic                addrWide,
  input  logic [ADDR_MAX-1:0] addr,
  input  logic [DATA_W-1:0]   wrData,
  input  dpStatus_t           status,
  output ctlStrobe_t          strobe,
  output logic                done,
  output logic                err,
  output logic [DATA_W-1:0]   rdData
);

  typedef enum logic [1:0] {C_IDLE, C_LAUNCH, C_WAIT} cState_e;

  cState_e             state;
  logic [2:0]          opQ;
  logic                wideQ;
  logic [ADDR_MAX-1:0] addrQ;
  logic [DATA_W-1:0]   dataQ;
  logic [STEP_W-1:0]   stepQ;
  logic                doneQ;
  logic                errQ;
  logic [DATA_W-1:0]   rdQ;

  logic [STEP_W-1:0]   lastStep;
  stepKind_e           kind;
  logic [3:0]          awBits;
  logic [ADDR_MAX-1:0] addrField;
  logic [FRAME_W-1:0]  addrExt;
  logic [LEN_W-1:0]    shortLen;
  logic [LEN_W-1:0]    longLen;

  function automatic stepKind_e kindOf(logic [2:0] op, logic [STEP_W-1:0] step);
    stepKind_e k;
    if (op == OP_WRITE) begin
      case (step)
        STEP_W'(1): k = K_WEN;
        STEP_W'(2): k = K_WRITE;
        STEP_W'(4): k = K_WDS;
        default:    k = K_POLL;
      endcase
    end else begin
      case (op)
        OP_READ:  k = K_READ;
        OP_ERASE: k = K_ERASE;
        OP_WEN:   k = K_WEN;
        OP_WDS:   k = K_WDS;
        default:  k = K_POLL;
      endcase
    end
    return k;
  endfunction

  assign lastStep  = (opQ == OP_WRITE) ? STEP_W'(WRITE_LAST_STEP) : '0;
  assign kind      = kindOf(opQ, stepQ);
  assign awBits    = wideQ ? 4'(ADDR_MAX) : 4'(ADDR_MIN);
  assign addrField = addrQ & (wideQ ? {ADDR_MAX{1'b1}} : ADDR_MAX'((1 << ADDR_MIN) - 1));
  assign addrExt   = FRAME_W'(addrField);
  assign shortLen  = LEN_W'(3) + LEN_W'(awBits);
  assign longLen   = shortLen + LEN_W'(DATA_W);

  always_comb begin
    strobe.launch  = (state == C_LAUNCH);
    strobe.isPoll  = 1'b0;
    strobe.len     = shortLen;
    strobe.pattern = '0;
    case (kind)
      K_READ: begin
        strobe.len     = longLen;
        strobe.pattern = ((FRAME_W'(CMD_READ) << awBits) | addrExt) << DATA_W;
      end
      K_WRITE: begin
        strobe.len     = longLen;
        strobe.pattern = (((FRAME_W'(CMD_WRITE) << awBits) | addrExt) << DATA_W)
                         | FRAME_W'(dataQ);
      end
      K_ERASE: strobe.pattern = (FRAME_W'(CMD_ERASE) << awBits) | addrExt;
      K_WEN:   strobe.pattern = FRAME_W'(ENABLE_SEED) << (awBits - 4'd4);
      K_WDS:   strobe.pattern = FRAME_W'(DISABLE_SEED) << (awBits - 4'd4);
      default: begin
        strobe.isPoll = 1'b1;
        strobe.len    = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= C_IDLE;
      opQ   <= '0;
      wideQ <= 1'b0;
      addrQ <= '0;
      dataQ <= '0;
      stepQ <= '0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      rdQ   <= '0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        C_IDLE: begin
          if (start) begin
            opQ   <= opSel;
            wideQ <= addrWide;
            addrQ <= addr;
            dataQ <= wrData;
            stepQ <= '0;
            state <= C_LAUNCH;
          end
        end
        C_LAUNCH: state <= C_WAIT;
        C_WAIT: begin
          if (status.stepDone) begin
            if (status.timedOut || stepQ == lastStep) begin
              doneQ <= 1'b1;
              errQ  <= status.timedOut;
              if (kind == K_READ) rdQ <= status.rxWord;
              state <= C_IDLE;
            end else begin
              stepQ <= stepQ + 1'b1;
              state <= C_LAUNCH;
            end
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  assign done   = doneQ;
  assign err    = errQ;
  assign rdData = rdQ;

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != C_IDLE) |=> ($stable(opQ) && $stable(addrQ)));

  assert_step_in_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    status.stepDone |-> (state == C_WAIT));

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !doneQ |-> $stable(rdQ));

endmodule

// File: rtl/sereep_engine.sv
module sereep_engine #(
  parameter int HALF_DIV   = 4,
  parameter int POLL_LIMIT = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  opSel,
  input  logic        addrWide,
  input  logic [7:0]  addr,
  input  logic [15:0] wrData,
  input  logic        misoIn,
  output logic        done,
  output logic        err,
  output logic [15:0] rdData,
  output logic        csOut,
  output logic        sclkOut,
  output logic        mosiOut
);

  import sereep_pkg::*;

  ctlStrobe_t ctlToDp;
  dpStatus_t  dpToCtl;

  sereep_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opSel    (opSel),
    .addrWide (addrWide),
    .addr     (addr),
    .wrData   (wrData),
    .status   (dpToCtl),
    .strobe   (ctlToDp),
    .done     (done),
    .err      (err),
    .rdData   (rdData)
  );

  sereep_dpath #(
    .HALF_DIV   (HALF_DIV),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (ctlToDp),
    .misoIn  (misoIn),
    .status  (dpToCtl),
    .csOut   (csOut),
    .sclkOut (sclkOut),
    .mosiOut (mosiOut)
  );

endmodule

// File: tb/sereep_engine_bench.sv
module sereep_engine_bench;

  localparam int HALF = 2;
  localparam int PLIM = 30;
  localparam int BUSY_CLKS = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] opSel = '0;
  logic addrWide = 1'b0;
  logic [7:0] addr = '0;
  logic [15:0] wrData = '0;
  logic misoIn;
  logic done, err, csOut, sclkOut, mosiOut;
  logic [15:0] rdData;

  always #5 clk = ~clk;

  sereep_engine #(.HALF_DIV(HALF), .POLL_LIMIT(PLIM)) u_sereep_engine (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .addrWide(addrWide),
    .addr(addr), .wrData(wrData), .misoIn(misoIn), .done(done), .err(err),
    .rdData(rdData), .csOut(csOut), .sclkOut(sclkOut), .mosiOut(mosiOut));

  int checks = 0;
  int failures = 0;

  // ---------------- device model ----------------
  int clkCount = 0;
  always @(posedge clk) clkCount <= clkCount + 1;

  int segCount = 0;
  int segLen [0:255];
  logic [31:0] segBits [0:255];
  int segDur [0:255];
  int curLen = 0;
  logic [31:0] curBits = '0;
  int segStart = 0;
  int lastFall = 0;
  int minGap = 1000000;
  logic frameAct = 1'b0;
  logic frameBit = 1'b0;
  int busyUntil = 0;
  int hdrLen = 99;
  logic [15:0] rdVal = '0;
  int curAw = 6;
  logic forceBusy = 1'b0;

  assign misoIn = frameAct ? frameBit : (!forceBusy && (clkCount >= busyUntil));

  always @(posedge sclkOut or posedge csOut or negedge csOut) begin
    if (!csOut) begin
      segLen[segCount % 256]  = curLen;
      segBits[segCount % 256] = curBits;
      segDur[segCount % 256]  = clkCount - segStart;
      segCount = segCount + 1;
      frameAct = 1'b0;
      lastFall = clkCount;
      if (curLen >= 3) begin
        if ((curLen == curAw + 19 && ((curBits >> (curLen - 3)) & 7) == 5) ||
            (curLen == curAw + 3 && ((curBits >> (curLen - 3)) & 7) == 7))
          busyUntil = clkCount + BUSY_CLKS;
      end
    end else if (sclkOut) begin
      curBits = {curBits[30:0], mosiOut};
      if (curLen >= hdrLen && curLen < hdrLen + 16) frameBit = rdVal[15 - (curLen - hdrLen)];
      else frameBit = 1'b0;
      frameAct = 1'b1;
      curLen = curLen + 1;
    end else begin
      curLen = 0;
      curBits = '0;
      segStart = clkCount;
      if (clkCount - lastFall < minGap) minGap = clkCount - lastFall;
    end
  end

  // ---------------- protocol monitors ----------------
  int mosiViol = 0;
  int idleViol = 0;
  int doneViol = 0;
  logic prevMosi = 1'b0;
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (mosiOut !== prevMosi && sclkOut) mosiViol = mosiViol + 1;
      if (!csOut && sclkOut) idleViol = idleViol + 1;
      if (done && prevDone) doneViol = doneViol + 1;
    end
    prevMosi = mosiOut;
    prevDone = done;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expBits(logic [2:0] op, logic wide, logic [7:0] a8, logic [15:0] d);
    int aw;
    logic [31:0] a;
    aw = wide ? 8 : 6;
    a = wide ? {24'd0, a8} : {24'd0, a8 & 8'h3F};
    case (op)
      3'd0:    return ((32'd6 << aw) | a) << 16;
      3'd1:    return (((32'd5 << aw) | a) << 16) | {16'd0, d};
      3'd2:    return (32'd7 << aw) | a;
      3'd3:    return 32'h4F << (aw - 4);
      3'd4:    return 32'h40 << (aw - 4);
      default: return 32'd0;
    endcase
  endfunction

  function automatic int expLen(logic [2:0] op, logic wide);
    int aw;
    aw = wide ? 8 : 6;
    case (op)
      3'd0, 3'd1:       return aw + 19;
      3'd2, 3'd3, 3'd4: return aw + 3;
      default:          return 0;
    endcase
  endfunction

  function automatic logic [15:0] devWord(logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  int base = 0;
  int gotDone = 0;

  task automatic runOp(input logic [2:0] op, input logic wide, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    curAw = wide ? 8 : 6;
    hdrLen = curAw + 3;
    rdVal = devWord(wide ? a : (a & 8'h3F));
    base = segCount;
    opSel = op; addrWide = wide; addr = a; wrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotDone = 0;
    for (int n = 0; n < 20000; n++) begin
      if (done) begin gotDone = 1; break; end
      @(negedge clk);
    end
  endtask

  // ---------------- table ----------------
  typedef struct packed {
    logic [2:0]  op;
    logic        wide;
    logic [7:0]  a;
    logic [15:0] d;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 8'h00, 16'h0000},
    '{3'd0, 1'b0, 8'h3F, 16'h0000},
    '{3'd0, 1'b0, 8'hC5, 16'h0000},
    '{3'd0, 1'b1, 8'hFF, 16'h0000},
    '{3'd0, 1'b1, 8'h81, 16'h0000},
    '{3'd2, 1'b0, 8'hEA, 16'h0000},
    '{3'd2, 1'b1, 8'hA7, 16'h0000},
    '{3'd3, 1'b0, 8'h00, 16'h0000},
    '{3'd3, 1'b1, 8'h00, 16'h0000},
    '{3'd4, 1'b1, 8'h00, 16'h0000},
    '{3'd4, 1'b0, 8'h00, 16'h0000},
    '{3'd5, 1'b1, 8'h00, 16'h0000}
  };

  task automatic checkWrite(input logic wide, input logic [7:0] a, input logic [15:0] d);
    runOp(3'd1, wide, a, d);
    chk("R12 write done", 32'(gotDone), 32'd1);
    chk("R4 write segments", 32'(segCount - base), 32'd6);
    chk("R12 write err", {31'd0, err}, 32'd0);
    chk("R4 seg0 poll", 32'(segLen[(base) % 256]), 32'd0);
    chk("R5 enable len", 32'(segLen[(base + 1) % 256]), 32'(expLen(3'd3, wide)));
    chk("R5 enable bits", segBits[(base + 1) % 256], expBits(3'd3, wide, a, d));
    chk("R4 write len", 32'(segLen[(base + 2) % 256]), 32'(expLen(3'd1, wide)));
    chk("R4 write bits", segBits[(base + 2) % 256], expBits(3'd1, wide, a, d));
    chk("R4 seg3 poll", 32'(segLen[(base + 3) % 256]), 32'd0);
    chk("R8 post-write poll waited", 32'(segDur[(base + 3) % 256] >= BUSY_CLKS / 2), 32'd1);
    chk("R5 disable len", 32'(segLen[(base + 4) % 256]), 32'(expLen(3'd4, wide)));
    chk("R5 disable bits", segBits[(base + 4) % 256], expBits(3'd4, wide, a, d));
    chk("R4 seg5 poll", 32'(segLen[(base + 5) % 256]), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    failures = failures + 1;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cs", {31'd0, csOut}, 32'd0);
    chk("R1 sclk", {31'd0, sclkOut}, 32'd0);
    chk("R1 mosi", {31'd0, mosiOut}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 rdData", {16'd0, rdData}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R3 R6 R5 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i].op, VECS[i].wide, VECS[i].a, VECS[i].d);
      chk("R12 done seen", 32'(gotDone), 32'd1);
      chk("R8 single segment", 32'(segCount - base), 32'd1);
      chk("R7 frame length", 32'(segLen[base % 256]), 32'(expLen(VECS[i].op, VECS[i].wide)));
      chk("R7 frame bits R3 R6", segBits[base % 256],
          expBits(VECS[i].op, VECS[i].wide, VECS[i].a, VECS[i].d));
      chk("R12 err clear", {31'd0, err}, 32'd0);
      if (VECS[i].op == 3'd0)
        chk("R3 read word", {16'd0, rdData},
            {16'd0, devWord(VECS[i].wide ? VECS[i].a : (VECS[i].a & 8'h3F))});
    end

    // R12: rdData unchanged by a non-read
    runOp(3'd0, 1'b1, 8'h42, 16'h0);
    runOp(3'd2, 1'b1, 8'h10, 16'h0);
    chk("R12 rdData held", {16'd0, rdData}, {16'd0, devWord(8'h42)});

    // R4 R5: guarded writes at both widths
    checkWrite(1'b0, 8'hD3, 16'hBEEF);
    checkWrite(1'b1, 8'hE1, 16'h1234);

    // R9: poll timeout
    forceBusy = 1'b1;
    runOp(3'd5, 1'b0, 8'h0, 16'h0);
    chk("R9 timeout done", 32'(gotDone), 32'd1);
    chk("R9 timeout err", {31'd0, err}, 32'd1);
    chk("R9 poll count", 32'(segDur[base % 256] >= PLIM * 2 * HALF), 32'd1);
    runOp(3'd1, 1'b1, 8'h22, 16'h5555);
    chk("R9 write aborted", 32'(segCount - base), 32'd1);
    chk("R9 write err", {31'd0, err}, 32'd1);
    forceBusy = 1'b0;
    runOp(3'd5, 1'b0, 8'h0, 16'h0);
    chk("R12 err cleared", {31'd0, err}, 32'd0);

    // R11: start while busy
    runOp(3'd0, 1'b0, 8'h15, 16'h0);
    base = segCount;
    @(negedge clk);
    rdVal = devWord(8'h2B); hdrLen = 9; curAw = 6;
    opSel = 3'd0; addrWide = 1'b0; addr = 8'h2B; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    opSel = 3'd1; addr = 8'h07; wrData = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotDone = 0;
    for (int n = 0; n < 600; n++) begin
      if (done) gotDone = gotDone + 1;
      @(negedge clk);
    end
    chk("R11 one done", 32'(gotDone), 32'd1);
    chk("R11 one segment", 32'(segCount - base), 32'd1);
    chk("R11 read intact", {16'd0, rdData}, {16'd0, devWord(8'h2B)});

    // Protocol monitors
    chk("R2 data stable while clock high", 32'(mosiViol), 32'd0);
    chk("R2 clock idles low", 32'(idleViol), 32'd0);
    chk("R12 done single cycle", 32'(doneViol), 32'd0);
    chk("R10 chip-select gap", 32'(minGap >= 2 * HALF), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule